// File: doc/BRIEF.md
# Global-History Correlating Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a shift register of the most recent resolved branch outcomes. It also keeps a table of 2-bit saturating counters. The counter for a branch is chosen by combining the branch address with that outcome history. As a result, the same branch can learn different behaviour depending on the path that led to it. This lets the block capture correlations between neighbouring branches and the exit pattern of short loops.

A fetch stage presents a branch address on the lookup side and reads back a taken/not-taken guess in the same cycle. When the branch resolves, the execute stage presents the address and the real outcome with a valid strobe. On the next clock edge the selected counter is trained and the outcome is shifted into the history. The table depth and the history length are both parameters.

Top module: `ghist_branch_predictor`

## Requirements
- R1: After reset every counter holds 01 (weakly not taken) and the history is all zeros, so every lookup returns not taken.
- R2: Counter encoding is 00 strongly not taken, 01 weakly not taken, 10 weakly taken, 11 strongly taken. The lookup result is taken exactly when the selected counter is 10 or 11.
- R3: A valid update with outcome taken adds one to the selected counter and holds it at 11 once there.
- R4: A valid update with outcome not taken subtracts one from the selected counter and holds it at 00 once there.
- R5: Each valid update shifts the history left by one; the new outcome enters bit 0 (1 = taken) and the oldest outcome falls out of the top bit.
- R6: The table index is address bits [ALIGN_W+IDX_W-1:ALIGN_W] XOR the history, zero-extended (or truncated) to IDX_W bits. All other address bits are ignored.
- R7: An update selects its counter with the history as it stood before that update's outcome is shifted in.
- R8: The lookup result is combinational from the registered state. When a lookup and an update hit the same counter in one cycle, the lookup returns the value held before that update.
- R9: With the update valid low, neither the counters nor the history change, whatever the other update inputs carry.
- R10: A counter at 11 needs two consecutive not-taken updates before its lookup result turns to not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_pc | input | PC_W | Address of the branch being looked up |
| pred_taken | output | 1 | Guess for pred_pc: 1 = taken |
| upd_valid | input | 1 | Strobe: a resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch: 1 = taken |

## Verification
A lookup result is due in the same cycle its address is applied, because it is purely combinational from stored state. The bench therefore drives pred_pc on the falling edge and samples pred_taken 1 ns later. An update is committed on the first rising edge while upd_valid is high. Its effect on counters and history is due from that edge onward, so the bench checks it on the following falling edge. The pre-update lookup for R8 is sampled before that rising edge. The bench's reference table and history are advanced only after the same rising edge, so expected and actual values always refer to the same cycle.

// File: rtl/gbp_pkg.sv
package gbp_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_e;

    localparam ctr_e CTR_RESET = CTR_WNT;

    function automatic ctr_e ctr_train(ctr_e cur, logic taken);
        ctr_e nxt;
        nxt = cur;
        unique case (cur)
            CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
            CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
            CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
            CTR_ST:  nxt = taken ? CTR_ST  : CTR_WT;
            default: nxt = CTR_RESET;
        endcase
        return nxt;
    endfunction

    function automatic logic ctr_says_taken(ctr_e c);
        return (c == CTR_WT) || (c == CTR_ST);
    endfunction

endpackage

// File: rtl/gbp_index.sv
module gbp_index #(
    parameter int PC_W    = 32,
    parameter int ALIGN_W = 2,
    parameter int IDX_W   = 6,
    parameter int HIST_W  = 5
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);

    localparam int TOP_BIT = ALIGN_W + IDX_W;

    logic [IDX_W-1:0] pc_field;
    logic [IDX_W-1:0] hist_fit;

    assign pc_field = pc[TOP_BIT-1:ALIGN_W];

    generate
        if (HIST_W >= IDX_W) begin : g_trunc
            assign hist_fit = hist[IDX_W-1:0];
            if (HIST_W > IDX_W) begin : g_spare
                logic unused_hist;
                assign unused_hist = ^hist[HIST_W-1:IDX_W];
            end
        end else begin : g_zext
            assign hist_fit = {{(IDX_W-HIST_W){1'b0}}, hist};
        end
    endgenerate

    generate
        if (TOP_BIT < PC_W) begin : g_pc_hi
            logic unused_pc_hi;
            assign unused_pc_hi = ^pc[PC_W-1:TOP_BIT];
        end
        if (ALIGN_W > 0) begin : g_pc_lo
            logic unused_pc_lo;
            assign unused_pc_lo = ^pc[ALIGN_W-1:0];
        end
    endgenerate

    assign idx = pc_field ^ hist_fit;

endmodule

// File: rtl/gbp_ghr.sv
module gbp_ghr #(
    parameter int HIST_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist
);

    typedef struct packed {
        logic [HIST_W-1:0] hist;
    } ghr_st_t;

    ghr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.hist = {st_q.hist[HIST_W-2:0], bit_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hist = st_q.hist;

    p_newest_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> st_q.hist[0] == $past(bit_in));

    p_older_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> st_q.hist[HIST_W-1:1] == $past(st_q.hist[HIST_W-2:0]));

    p_hist_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(st_q.hist));

endmodule

// File: rtl/gbp_pht.sv
module gbp_pht
    import gbp_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_e             rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        ctr_e [DEPTH-1:0] tbl;
    } pht_st_t;

    pht_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int e = 0; e < DEPTH; e++) begin
            if (wr_en && (wr_idx == IDX_W'(e))) begin
                st_d.tbl[e] = ctr_train(st_q.tbl[e], wr_taken);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) begin
                st_q.tbl[e] <= CTR_RESET;
            end
        end else begin
            st_q <= st_d;
        end
    end

    // Read returns the registered value, so a same-cycle write is not visible.
    assign rd_ctr = st_q.tbl[rd_idx];

    p_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && st_q.tbl[wr_idx] != CTR_ST)
        |=> st_q.tbl[$past(wr_idx)] == ctr_e'($past(st_q.tbl[wr_idx]) + 2'd1));

    p_top_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && st_q.tbl[wr_idx] == CTR_ST)
        |=> st_q.tbl[$past(wr_idx)] == CTR_ST);

    p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && st_q.tbl[wr_idx] != CTR_SNT)
        |=> st_q.tbl[$past(wr_idx)] == ctr_e'($past(st_q.tbl[wr_idx]) - 2'd1));

    p_bot_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && st_q.tbl[wr_idx] == CTR_SNT)
        |=> st_q.tbl[$past(wr_idx)] == CTR_SNT);

    p_tbl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q));

endmodule

// File: rtl/ghist_branch_predictor.sv
module ghist_branch_predictor
    import gbp_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ALIGN_W = 2,
    parameter int IDX_W   = 6,
    parameter int HIST_W  = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);

    logic [HIST_W-1:0] hist;
    logic [IDX_W-1:0]  pred_idx;
    logic [IDX_W-1:0]  upd_idx;
    ctr_e              pred_ctr;

    gbp_index #(
        .PC_W(PC_W), .ALIGN_W(ALIGN_W), .IDX_W(IDX_W), .HIST_W(HIST_W)
    ) u_pred_index (
        .pc  (pred_pc),
        .hist(hist),
        .idx (pred_idx)
    );

    // Uses the history before this outcome is shifted in.
    gbp_index #(
        .PC_W(PC_W), .ALIGN_W(ALIGN_W), .IDX_W(IDX_W), .HIST_W(HIST_W)
    ) u_upd_index (
        .pc  (upd_pc),
        .hist(hist),
        .idx (upd_idx)
    );

    gbp_ghr #(
        .HIST_W(HIST_W)
    ) u_ghr (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(upd_valid),
        .bit_in  (upd_taken),
        .hist    (hist)
    );

    gbp_pht #(
        .IDX_W(IDX_W)
    ) u_pht (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (pred_idx),
        .rd_ctr  (pred_ctr),
        .wr_en   (upd_valid),
        .wr_idx  (upd_idx),
        .wr_taken(upd_taken)
    );

    assign pred_taken = ctr_says_taken(pred_ctr);

    p_lookup_known_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(pred_pc) |-> !$isunknown(pred_taken));

endmodule

// File: tb/sim_ghist_branch_predictor.sv
`timescale 1ns/1ps
module sim_ghist_branch_predictor;

    localparam int PC_W = 32;
    localparam int IDX_W = 6;
    localparam int HIST_W = 5;
    localparam int DEPTH = 64;
    localparam logic [PC_W-1:0] HI_OFS = 32'h4000_0000;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            taken;
    } vec_t;

    // Loop branch (3 taken then exit) interleaved with a branch that repeats it.
    localparam vec_t VECS [12] = '{
        '{32'h0000_0100, 1'b1}, '{32'h0000_0140, 1'b1},
        '{32'h0000_0100, 1'b1}, '{32'h0000_0140, 1'b1},
        '{32'h0000_0100, 1'b1}, '{32'h0000_0140, 1'b1},
        '{32'h0000_0100, 1'b0}, '{32'h0000_0140, 1'b0},
        '{32'h0000_0208, 1'b1}, '{32'h0000_0208, 1'b0},
        '{32'h0000_031c, 1'b1}, '{32'h0000_0100, 1'b0}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] pred_pc = '0;
    logic            pred_taken;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    int ref_cnt [DEPTH];
    logic [HIST_W-1:0] ref_hist = '0;

    always #2.5 clk = ~clk;

    ghist_branch_predictor u0 (
        .clk(clk), .rst_n(rst_n),
        .pred_pc(pred_pc), .pred_taken(pred_taken),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    function automatic int ref_idx(logic [PC_W-1:0] pc);
        return int'((pc[7:2] ^ {1'b0, ref_hist}) & 6'h3f);
    endfunction

    function automatic logic [PC_W-1:0] pc_for(int e);
        logic [5:0] f;
        f = 6'(e) ^ {1'b0, ref_hist};
        return HI_OFS | {24'd0, f, 2'b00};
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic lookup(input logic [PC_W-1:0] pc, input logic exp, input string tag);
        pred_pc = pc;
        #1;
        chk(pred_taken, exp, tag);
    endtask

    task automatic lookup_model(input logic [PC_W-1:0] pc, input string tag);
        lookup(pc, ref_cnt[ref_idx(pc)] >= 2, tag);
    endtask

    task automatic model_train(input logic [PC_W-1:0] pc, input logic t);
        int e;
        e = ref_idx(pc);
        if (t) begin
            if (ref_cnt[e] < 3) ref_cnt[e]++;
        end else begin
            if (ref_cnt[e] > 0) ref_cnt[e]--;
        end
        ref_hist = {ref_hist[HIST_W-2:0], t};
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic update(input logic [PC_W-1:0] pc, input logic t);
        upd_pc = pc;
        upd_taken = t;
        upd_valid = 1'b1;
        @(posedge clk);
        model_train(pc, t);
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < DEPTH; i++) begin
            lookup_model(HI_OFS | (i << 2), tag);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_cnt[i] = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: every entry weakly not taken after reset
        for (int i = 0; i < DEPTH; i++) lookup(i << 2, 1'b0, "R1 reset lookup");

        // R3/R10/R4: drive one counter through its range (entry 5)
        update(pc_for(5), 1'b1); lookup(pc_for(5), 1'b1, "R3 01->10 R2 taken");
        update(pc_for(5), 1'b1); lookup(pc_for(5), 1'b1, "R3 10->11");
        update(pc_for(5), 1'b1); lookup(pc_for(5), 1'b1, "R3 hold 11");
        update(pc_for(5), 1'b1); lookup(pc_for(5), 1'b1, "R3 hold 11 again");
        update(pc_for(5), 1'b0); lookup(pc_for(5), 1'b1, "R10 first miss keeps taken");
        update(pc_for(5), 1'b0); lookup(pc_for(5), 1'b0, "R10 second miss flips");
        update(pc_for(5), 1'b0); lookup(pc_for(5), 1'b0, "R4 01->00");
        update(pc_for(5), 1'b0); lookup(pc_for(5), 1'b0, "R4 hold 00");
        update(pc_for(5), 1'b1); lookup(pc_for(5), 1'b0, "R4 00 then taken gives 01");
        update(pc_for(5), 1'b1); lookup(pc_for(5), 1'b1, "R2 10 predicts taken");

        // R7: update uses history before its own shift (entry 9)
        update(pc_for(9), 1'b1);
        lookup(pc_for(9), 1'b1, "R7 old-history entry trained");

        // R8: same-cycle lookup sees pre-update counter (entry 12)
        pred_pc = pc_for(12); upd_pc = pc_for(12); upd_taken = 1'b1; upd_valid = 1'b1;
        #1; chk(pred_taken, 1'b0, "R8 pre-update value 01");
        @(posedge clk); model_train(pc_for(12), 1'b1);
        @(negedge clk); upd_valid = 1'b0;
        lookup(pc_for(12), 1'b1, "R8 after commit 10");
        pred_pc = pc_for(12); upd_pc = pc_for(12); upd_taken = 1'b0; upd_valid = 1'b1;
        #1; chk(pred_taken, 1'b1, "R8 pre-update value 10");
        @(posedge clk); model_train(pc_for(12), 1'b0);
        @(negedge clk); upd_valid = 1'b0;
        lookup(pc_for(12), 1'b0, "R8 after commit 01");

        // R9: strobe low leaves counters and history untouched (entry 20)
        update(pc_for(20), 1'b1);
        upd_pc = pc_for(20); upd_taken = 1'b0; upd_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        lookup(pc_for(20), 1'b1, "R9 counter unchanged");
        sweep("R9 history unchanged");

        // R5/R2: table walk against reference model
        for (int pass = 0; pass < 20; pass++) begin
            for (int v = 0; v < 12; v++) begin
                lookup_model(VECS[v].pc, "R5 vector walk");
                update(VECS[v].pc, VECS[v].taken);
            end
        end

        // R6: alignment and high address bits ignored
        for (int i = 0; i < DEPTH; i++) begin
            lookup_model((i << 2) | 32'h3 | 32'hff00_0000, "R6 ignored bits");
        end
        sweep("R5 final state");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule